// File: doc/BRIEF.md
# Real-time clock prescaler divider

This block turns a slow stream of input enables (one per period of the real-time clock source) into a one-cycle time-base tick. The tick feeds a seconds counter that sits outside the block. The division ratio is a 20-bit reload value plus one. Software writes that value through two 16-bit registers: one holds bits 19:16 and one holds bits 15:0. A 20-bit down-counter does the division. Software can read the counter live through two read-only 16-bit registers without pausing it.

Any write to either reload register restarts the divider at once from the new value. A pulse on the main-counter-write input also restarts it. Because of this, software that sets the time or changes the ratio always starts a whole tick period cleanly. With a 32.768 kHz enable stream and a reload value of 0x07FFF, one tick comes out every second.

Register map (byte offsets):

| Offset | Access | Contents |
|--------|--------|----------|
| 0x08 | write only | reload bits 19:16 |
| 0x0C | write only | reload bits 15:0 |
| 0x10 | read only | divider count bits 19:16 |
| 0x14 | read only | divider count bits 15:0 |

Top module: `rtc_prescaler`

## Requirements
- R1: After reset the reload value and the divider both hold 0x08000, `tick_o` is 0, a read of offset 0x10 returns 0x0000 and a read of offset 0x14 returns 0x8000.
- R2: A write to offset 0x0C sets reload bits 15:0 from `bus_wdata[15:0]`. A write to offset 0x08 sets reload bits 19:16 from `bus_wdata[3:0]`, and `bus_wdata[15:4]` is ignored.
- R3: On each cycle with `tick_en` high and no reload request, a non-zero divider decrements by one. With `tick_en` low and no reload request, the divider holds its value.
- R4: On a cycle with `tick_en` high, no reload request and a divider of zero, the divider reloads from the stored reload value and `tick_o` is high for the following cycle only. With the enable held high, ticks therefore repeat every reload+1 enables.
- R5: A write to offset 0x08 or 0x0C, or a cycle with `cnt_wr` high, loads the divider with the reload value as updated by that write. The new divider value is visible from the next cycle.
- R6: With `bus_re` high, offset 0x10 returns divider bits 19:16 in `bus_rdata[3:0]` and zeros in bits 15:4, and offset 0x14 returns divider bits 15:0, in the same cycle. With `bus_re` low, `bus_rdata` is 0.
- R7: Reading the divider registers never changes the count sequence.
- R8: A reload request takes priority over a decrement or a zero-reload in the same cycle, and `tick_o` stays low in the following cycle.
- R9: Reads of offsets 0x08 and 0x0C, and of any unmapped offset, return 0. Writes to offsets 0x10 and 0x14 have no effect on the divider or the reload value.
- R10: With the reload value at 0x07FFF and `tick_en` high every cycle, successive ticks are exactly 32768 cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One pulse per period of the real-time clock source |
| bus_addr | input | 5 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_re | input | 1 | Register read strobe |
| bus_rdata | output | 16 | Register read data, combinational |
| cnt_wr | input | 1 | Pulse marking a write to the main seconds counter |
| tick_o | output | 1 | One-cycle time-base tick |

## Verification
The divider is run with the enable held high and with the enable paused part-way through, so that decrement steps can be told apart from held cycles. Small reload values are used to place the zero-crossing tick exactly and to show that it lasts a single cycle. A reload request is made on the very cycle the count sits at zero, which shows whether the restart beats the tick. A continuous read during counting checks that observing the count does not disturb it. The full one-second ratio is then measured tick to tick to show the count is exactly reload+1 and not off by one.

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CNT_W = 20,
  parameter logic [CNT_W-1:0] RELOAD_RST = 20'h08000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_re,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cnt_wr,
  output logic              tick_o
);
  localparam int HI_W = CNT_W - DATA_W;
  localparam logic [ADDR_W-1:0] OFS_RLD_HI = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_RLD_LO = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_DIV_HI = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] OFS_DIV_LO = ADDR_W'(8'h14);

  logic [CNT_W-1:0] reload_q, reload_d, div_q;
  logic wr_hi, wr_lo, force_ld, at_zero;

  assign wr_hi    = bus_we && (bus_addr == OFS_RLD_HI);
  assign wr_lo    = bus_we && (bus_addr == OFS_RLD_LO);
  assign force_ld = wr_hi || wr_lo || cnt_wr;
  assign at_zero  = (div_q == '0);

  always_comb begin
    reload_d = reload_q;
    if (wr_hi) reload_d[CNT_W-1:DATA_W] = bus_wdata[HI_W-1:0];
    if (wr_lo) reload_d[DATA_W-1:0] = bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= RELOAD_RST;
      div_q    <= RELOAD_RST;
      tick_o   <= 1'b0;
    end else begin
      reload_q <= reload_d;
      tick_o   <= 1'b0;
      if (force_ld) begin
        div_q <= reload_d;
      end else if (tick_en) begin
        if (at_zero) begin
          div_q  <= reload_q;
          tick_o <= 1'b1;
        end else begin
          div_q <= div_q - 1'b1;
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_re) begin
      case (bus_addr)
        OFS_DIV_HI: bus_rdata[HI_W-1:0] = div_q[CNT_W-1:DATA_W];
        OFS_DIV_LO: bus_rdata = div_q[DATA_W-1:0];
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/rtc_prescaler_chk.sv
module rtc_prescaler_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 16,
  parameter int CNT_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic              bus_re,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              cnt_wr,
  input logic              tick_o,
  input logic [CNT_W-1:0]  div_q,
  input logic [CNT_W-1:0]  reload_q
);
  localparam int HI_W = CNT_W - DATA_W;
  logic req;
  assign req = cnt_wr || (bus_we && (bus_addr == ADDR_W'(8'h08) || bus_addr == ADDR_W'(8'h0C)));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !req) |=> $stable(div_q));
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !req && div_q != '0) |=> (div_q == $past(div_q) - 1'b1) && !tick_o);
  p_zero_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !req && div_q == '0) |=> tick_o && (div_q == $past(reload_q)));
  p_force_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> div_q == reload_q);
  p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !tick_o);
  p_high_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(8'h10)) |-> bus_rdata[DATA_W-1:HI_W] == '0);
  p_idle_bus_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> bus_rdata == '0);
  p_wo_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && (bus_addr == ADDR_W'(8'h08) || bus_addr == ADDR_W'(8'h0C))) |-> bus_rdata == '0);
endmodule

bind rtc_prescaler rtc_prescaler_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_re(bus_re), .bus_rdata(bus_rdata), .cnt_wr(cnt_wr), .tick_o(tick_o),
  .div_q(div_q), .reload_q(reload_q)
);

// File: tb/test_rtc_prescaler.sv
module test_rtc_prescaler;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] RH = 5'h08, RL = 5'h0C, DH = 5'h10, DL = 5'h14;

  logic clk = 0, rst_n = 0, tick_en = 0, bus_we = 0, bus_re = 0, cnt_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic tick_o;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_prescaler i_rtc_prescaler (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(bus_rdata), .cnt_wr(cnt_wr), .tick_o(tick_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [15:0] d);
    bus_addr = a; bus_re = 1; #1; d = bus_rdata; bus_re = 0;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    @(negedge clk);
    chk("R1 tick", tick_o, 0);
    rd(DH, d); chk("R1 div hi", d, 16'h0000);
    rd(DL, d); chk("R1 div lo", d, 16'h8000);
  endtask

  task automatic t_program;
    logic [15:0] d;
    wr(RH, 16'hFFF5);
    rd(DH, d); chk("R2/R5 hi after hi write", d, 16'h0005);
    rd(DL, d); chk("R5 lo after hi write", d, 16'h8000);
    wr(RL, 16'h1234);
    rd(DL, d); chk("R2/R5 lo", d, 16'h1234);
    rd(DH, d); chk("R2 hi kept", d, 16'h0005);
    rd(RH, d); chk("R9 read reload hi", d, 0);
    rd(RL, d); chk("R9 read reload lo", d, 0);
    wr(DL, 16'h0000); wr(DH, 16'h000F);
    rd(DL, d); chk("R9 write div lo ignored", d, 16'h1234);
    rd(DH, d); chk("R9 write div hi ignored", d, 16'h0005);
    bus_re = 0; #1; chk("R6 idle rdata", bus_rdata, 0);
  endtask

  task automatic t_count;
    logic [15:0] d;
    wr(RH, 0); wr(RL, 3);
    rd(DL, d); chk("R5 small reload", d, 3);
    tick_en = 1; @(negedge clk); @(negedge clk); tick_en = 0;
    rd(DL, d); chk("R3 two decrements", d, 1);
    repeat (3) @(negedge clk);
    rd(DL, d); chk("R3 hold without enable", d, 1);
    tick_en = 1;
    @(negedge clk); chk("R4 no tick at 1->0", tick_o, 0);
    @(negedge clk); chk("R4 tick after zero", tick_o, 1);
    rd(DL, d); chk("R4 reload at zero", d, 3);
    @(negedge clk); chk("R4 tick one cycle", tick_o, 0);
    tick_en = 0;
  endtask

  task automatic t_period;
    int n = 0;
    wr(RL, 3);
    tick_en = 1;
    for (int i = 0; i < 12; i++) begin @(negedge clk); if (tick_o) n++; end
    tick_en = 0;
    chk("R4 three ticks in twelve enables", n, 3);
  endtask

  task automatic t_live_read;
    logic [15:0] exp = 3;
    wr(RL, 3);
    tick_en = 1;
    for (int i = 0; i < 9; i++) begin
      bus_addr = DL; bus_re = 1; #1;
      chk("R7 live read", bus_rdata, exp);
      @(negedge clk);
      exp = (exp == 0) ? 16'd3 : exp - 1'b1;
    end
    bus_re = 0; tick_en = 0;
  endtask

  task automatic t_force;
    logic [15:0] d;
    wr(RL, 3);
    tick_en = 1; repeat (3) @(negedge clk);
    rd(DL, d); chk("R3 at zero before force", d, 0);
    cnt_wr = 1; @(negedge clk); cnt_wr = 0; tick_en = 0;
    chk("R8 no tick on forced cycle", tick_o, 0);
    rd(DL, d); chk("R5/R8 counter write reloads", d, 3);
    tick_en = 1; @(negedge clk); tick_en = 0;
    rd(DL, d); chk("R5 counting resumes", d, 2);
  endtask

  task automatic t_second;
    int n = 0;
    wr(RL, 16'h7FFF);
    tick_en = 1;
    while (!tick_o) begin @(negedge clk); n++; end
    chk("R10 first tick", n, 32768);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_o);
    chk("R10 tick spacing", n, 32768);
    tick_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_program();
    t_count();
    t_period();
    t_live_read();
    t_force();
    t_second();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule